// File: doc/BRIEF.md
# Serial IRQ host frame controller

This block is the host end of a single-wire serial interrupt bus clocked by the PCI clock. Every bus cycle it opens with a start frame, then walks 21 interrupt slots of three clocks each, and closes with a stop frame. A peripheral signals an interrupt by pulling the line low in its slot's sample clock. The host latches that slot as asserted and publishes all 21 results at once when the stop frame begins.

The line is open-drain with a pull-up. It uses sustained tri-state signalling: after driving low, the driver drives high for one clock and then releases the line. The controller never drives the line during the slots.

The bus has two modes. In continuous mode the host opens every cycle itself. In quiet mode the line idles high until a peripheral pulls it low, and the host then completes that start frame. The stop frame's length tells the peripherals which mode applies to the next cycle. The host always runs in continuous mode first after reset.

Top module: `serirq_host`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the line is released (`oe_o` low) and `irq_o` is all zeros. The first start frame then begins, in continuous mode.
- R2: A start frame in continuous mode drives the line low for a number of clocks set by `width_sel_i`, sampled on the clock edge that opens the frame: 00 gives 4, 01 gives 6, 10 gives 8, and 11 gives 4.
- R3: Every host low period, start or stop, is followed by exactly one clock driven high and then one clock released.
- R4: Slot 0's sample clock comes right after the start frame's released clock. Slots 0 to 20 follow back to back, each as a sample, recovery and turn-around clock. The host keeps the line released for all 63 slot clocks.
- R5: Bit i of `irq_o` (bit 0 = slot 0, bit 20 = slot 20) is 1 exactly when the line was low at the sample clock of slot i.
- R6: `irq_o` changes only on the first clock of a stop frame, where all 21 bits are replaced in one step. At every other time it holds its value.
- R7: `quiet_req_i` is sampled at the edge that ends slot 20's turn-around clock. If it is 1, the stop frame is 2 clocks low and the next cycle runs in quiet mode. If it is 0, the stop frame is 3 clocks low and the next cycle runs in continuous mode.
- R8: In continuous mode the next start frame's first low clock comes right after the stop frame's released clock.
- R9: In quiet mode the line stays released after the stop frame for as long as the line reads high.
- R10: In quiet mode, a clock with the line read low counts as the first start-frame clock. The host then drives low for one clock fewer than the R2 width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Sensed level of the shared line |
| width_sel_i | input | 2 | Start-frame width code |
| quiet_req_i | input | 1 | 1 requests quiet mode for the next cycle |
| oe_o | output | 1 | Host drives the line when 1 |
| drive_o | output | 1 | Level driven while `oe_o` is 1 |
| irq_o | output | 21 | Captured interrupt slots, bit i = slot i |

## Verification
The bench covers every width code, including the 11 alias that must give 4 clocks. It also checks the one-clock-shorter start after a peripheral opens a quiet frame; a design that miscounts the peripheral's clock drives one clock too many or too few. Slot patterns exercise bit 0, bit 20, all-ones and all-zeros, so an off-by-one in the slot phase would shift or drop bits in `irq_o`. The bench flags any change to `irq_o` before the stop frame, and checks the 2-clock and 3-clock stop lengths together with the mode that follows each. A design that got the mode wrong would either drive during the quiet idle or fail to restart in continuous mode.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_START_REC,
    ST_START_TA,
    ST_SLOT,
    ST_STOP,
    ST_STOP_REC,
    ST_STOP_TA
  } frame_st_e;

  // start-frame low length in clocks; code 3 aliases to 4
  function automatic logic [3:0] start_clocks(input logic [1:0] code);
    case (code)
      2'b01:   return 4'd6;
      2'b10:   return 4'd8;
      default: return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/serirq_seq.sv
module serirq_seq
  import serirq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 21,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic [1:0]        width_sel_i,
  input  logic              quiet_req_i,
  output frame_st_e         state_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              sample_o,
  output logic              frame_done_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  frame_st_e         state_q;
  logic [3:0]        cnt_q;
  logic [1:0]        phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic              quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      phase_q <= '0;
      slot_q  <= '0;
      quiet_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!quiet_q) begin
            state_q <= ST_START;
            cnt_q   <= start_clocks(width_sel_i) - 4'd1;
          end else if (!line_i) begin
            // peripheral supplied the first clock
            state_q <= ST_START;
            cnt_q   <= start_clocks(width_sel_i) - 4'd2;
          end
        end
        ST_START: begin
          if (cnt_q == '0) state_q <= ST_START_REC;
          else             cnt_q   <= cnt_q - 4'd1;
        end
        ST_START_REC: state_q <= ST_START_TA;
        ST_START_TA: begin
          state_q <= ST_SLOT;
          slot_q  <= '0;
          phase_q <= '0;
        end
        ST_SLOT: begin
          if (phase_q == 2'd2) begin
            phase_q <= '0;
            if (slot_q == LAST_SLOT) begin
              state_q <= ST_STOP;
              cnt_q   <= quiet_req_i ? 4'd1 : 4'd2;
              quiet_q <= quiet_req_i;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end else begin
            phase_q <= phase_q + 2'd1;
          end
        end
        ST_STOP: begin
          if (cnt_q == '0) state_q <= ST_STOP_REC;
          else             cnt_q   <= cnt_q - 4'd1;
        end
        ST_STOP_REC: state_q <= ST_STOP_TA;
        ST_STOP_TA: begin
          if (quiet_q) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_START;
            cnt_q   <= start_clocks(width_sel_i) - 4'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o      = state_q;
  assign slot_o       = slot_q;
  assign sample_o     = (state_q == ST_SLOT) && (phase_q == 2'd0);
  assign frame_done_o = (state_q == ST_SLOT) && (phase_q == 2'd2) && (slot_q == LAST_SLOT);

  p_slot_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q < SLOT_W'(NUM_SLOTS));

  p_start_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START) |-> (cnt_q <= 4'd7));

  p_stop_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP_REC) |-> ($past(state_q, 2) == ST_STOP));

  p_quiet_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && quiet_q && line_i) |=> (state_q == ST_IDLE));

  p_quiet_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && quiet_q && !line_i) |=> (state_q == ST_START));

endmodule

// File: rtl/serirq_capture.sv
module serirq_capture #(
  parameter int unsigned NUM_SLOTS = 21,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_i,
  input  logic                 sample_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic                 done_i,
  output logic [NUM_SLOTS-1:0] irq_o
);

  logic [NUM_SLOTS-1:0] shadow_q;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                shadow_q[i] <= 1'b0;
      else if (sample_i && slot_i == SLOT_W'(i))  shadow_q[i] <= ~line_i;
    end
  end

  // publish all slots together so readers never see a mixed frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_o <= '0;
    else if (done_i) irq_o <= shadow_q;
  end

  p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(irq_o));

endmodule

// File: rtl/serirq_drv.sv
module serirq_drv
  import serirq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  frame_st_e state_i,
  output logic      oe_o,
  output logic      drive_o
);

  always_comb begin
    oe_o    = 1'b0;
    drive_o = 1'b1;
    case (state_i)
      ST_START, ST_STOP:         begin oe_o = 1'b1; drive_o = 1'b0; end
      ST_START_REC, ST_STOP_REC: begin oe_o = 1'b1; drive_o = 1'b1; end
      default: ;
    endcase
  end

  p_high_after_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !drive_o) |=> oe_o);

  p_release_after_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && drive_o) |=> !oe_o);

endmodule

// File: rtl/serirq_host.sv
module serirq_host
  import serirq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 21,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_i,
  input  logic [1:0]           width_sel_i,
  input  logic                 quiet_req_i,
  output logic                 oe_o,
  output logic                 drive_o,
  output logic [NUM_SLOTS-1:0] irq_o
);

  frame_st_e         state;
  logic [SLOT_W-1:0] slot;
  logic              sample;
  logic              frame_done;

  serirq_seq #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_i      (line_i),
    .width_sel_i (width_sel_i),
    .quiet_req_i (quiet_req_i),
    .state_o     (state),
    .slot_o      (slot),
    .sample_o    (sample),
    .frame_done_o(frame_done)
  );

  serirq_capture #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .sample_i(sample),
    .slot_i  (slot),
    .done_i  (frame_done),
    .irq_o   (irq_o)
  );

  serirq_drv i_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_i(state),
    .oe_o   (oe_o),
    .drive_o(drive_o)
  );

  p_no_drive_in_slots_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample |-> !oe_o);

endmodule

// File: tb/test_serirq_host.sv
module test_serirq_host;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line;
  logic [1:0]  width_sel = 2'b00;
  logic        quiet_req = 1'b0;
  logic        oe, drv;
  logic [20:0] irq;
  logic        periph_low = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [20:0] exp_q[$];
  logic [20:0] last_mask = '0;
  int  low_runs = 0;
  bit  prev_low = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // open-drain line with pull-up
  assign line = oe ? drv : ~periph_low;

  serirq_host i_serirq_host (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .line_i     (line),
    .width_sel_i(width_sel),
    .quiet_req_i(quiet_req),
    .oe_o       (oe),
    .drive_o    (drv),
    .irq_o      (irq)
  );

  task automatic expect_line(input bit e_oe, input bit e_drv, input string req, input string what);
    checks++;
    if (oe !== e_oe || (e_oe && drv !== e_drv)) begin
      errors++;
      $display("FAIL %s %s: oe/drive=%b/%b expected %b/%b", req, what, oe, drv, e_oe, e_drv);
    end
  endtask

  task automatic expect_irq(input logic [20:0] exp, input string req, input string what);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s %s: irq=%h expected %h", req, what, irq, exp);
    end
  endtask

  // entry: negedge of first host-low start clock; exit: negedge after stop turn-around
  task automatic run_frame(input int n_start, input string start_req, input logic [20:0] mask,
                           input bit quiet_next, input logic [1:0] next_w);
    for (int i = 0; i < n_start; i++) begin
      expect_line(1'b1, 1'b0, start_req, "start low");
      @(negedge clk);
    end
    width_sel = next_w;
    quiet_req = quiet_next;
    expect_line(1'b1, 1'b1, "R3", "start recovery");
    @(negedge clk);
    expect_line(1'b0, 1'b1, "R3", "start turn-around");
    @(negedge clk);
    exp_q.push_back(mask);
    for (int s = 0; s < 21; s++) begin
      for (int p = 0; p < 3; p++) begin
        expect_line(1'b0, 1'b1, "R4", "slot released");
        periph_low = (p == 0) && mask[s];
        if (s == 20 && p == 2) expect_irq(last_mask, "R6", "held before stop");
        @(negedge clk);
      end
    end
    periph_low = 1'b0;
    last_mask = mask;
    for (int i = 0; i < (quiet_next ? 2 : 3); i++) begin
      expect_line(1'b1, 1'b0, "R7", "stop low");
      @(negedge clk);
    end
    expect_line(1'b1, 1'b1, "R3", "stop recovery");
    @(negedge clk);
    expect_line(1'b0, 1'b1, "R3", "stop turn-around");
    @(negedge clk);
  endtask

  task automatic quiet_idle(input int n);
    for (int i = 0; i < n; i++) begin
      expect_line(1'b0, 1'b1, "R9", "quiet idle");
      @(negedge clk);
    end
    periph_low = 1'b1;
    expect_line(1'b0, 1'b1, "R10", "peripheral start clock");
    @(negedge clk);
    periph_low = 1'b0;
  endtask

  // monitor: host low runs alternate start, stop; each stop publishes a frame
  always @(negedge clk) begin
    if (!rst_ni) begin
      prev_low = 1'b0;
      low_runs = 0;
    end else begin
      if (oe && !drv && !prev_low) begin
        low_runs++;
        if (low_runs % 2 == 0) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R5 unexpected stop frame: irq=%h expected none", irq);
          end else begin
            logic [20:0] e;
            e = exp_q.pop_front();
            if (irq !== e) begin
              errors++;
              $display("FAIL R5 captured slots: irq=%h expected %h", irq, e);
            end
          end
        end
      end
      prev_low = oe && !drv;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_line(1'b0, 1'b1, "R1", "in reset");
    expect_irq('0, "R1", "in reset");
    rst_ni = 1'b1;
    expect_line(1'b0, 1'b1, "R1", "first clock");
    @(negedge clk);
    run_frame(4, "R2", 21'h0A5A5A, 1'b0, 2'b01);  // R8 next
    run_frame(6, "R2", 21'h1F00F1, 1'b0, 2'b10);
    run_frame(8, "R2", 21'h1FFFFF, 1'b1, 2'b01);
    quiet_idle(12);
    run_frame(5, "R10", 21'h000000, 1'b0, 2'b11);
    run_frame(4, "R2", 21'h100000, 1'b1, 2'b10);
    quiet_idle(5);
    run_frame(7, "R10", 21'h000001, 1'b0, 2'b00);
    run_frame(4, "R8", 21'h000000, 1'b1, 2'b00);
    repeat (2) @(negedge clk);
    expect_line(1'b0, 1'b1, "R9", "final idle");
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 frames unpublished: %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule